// File: doc/BRIEF.md
# Microcoded 8-bit Datapath Core

This block is an 8-bit datapath that can do a different operation on every clock cycle. It holds two accumulators, two data registers and two 4-entry FIFOs. An eight-entry control store holds configuration words. Each cycle, a 3-bit address selects one of those words. The selected word sets the ALU function, the shift function, where the two ALU operands come from, and what each accumulator loads at the next clock edge.

Integration works in two phases:

- **While reset is held:** the surrounding logic loads the control store.
- **After reset is released:** it writes the data registers through a preload port, pushes values into the FIFOs, and sequences the datapath by driving the configuration address. The configuration address would typically come from its own state machine.

The ALU/shifter result is visible at all times as a combinational output. Each FIFO reports its empty, full, overflow and underflow status.

The block is not a state machine in its own right. It has two operating conditions:

- **Load:** reset is asserted. The control store accepts writes and all datapath state is cleared.
- **Run:** reset is released. The control store is frozen and the selected word is executed on every edge.

Deasserting reset moves the block from Load to Run. Asserting reset returns it to Load.

Top module: `ucode_dp8`

## Requirements
- R1: The configuration word is 13 bits: [12:10] ALU function, [9:8] shift function, [7] operand A source, [6:4] operand B source, [3:2] accumulator 0 write source, [1:0] accumulator 1 write source. `cfg_addr` selects the active word in the same cycle, and `result` follows it combinationally.
- R2: ALU codes are 0 PASS (A), 1 INC (A+1), 2 DEC (A-1), 3 ADD (A+B), 4 SUB (A-B), 5 XOR, 6 AND, 7 OR. All arithmetic wraps modulo 256.
- R3: Shift codes are 0 pass, 1 shift left by one with zero fill, 2 shift right by one with zero fill, 3 nibble swap. The shift is applied to the ALU output, and the shifted value is `result`.
- R4: Operand A code 0 selects accumulator 0 and code 1 selects accumulator 1. Operand B codes are 0 D0, 1 D1, 2 F0 head, 3 F1 head, 4 accumulator 0, 5 accumulator 1; codes 6 and 7 give zero.
- R5: Accumulator 0 write codes are 0 hold, 1 `result`, 2 D0, 3 F0 head. Accumulator 1 write codes are 0 hold, 1 `result`, 2 D1, 3 F1 head. When both accumulators load in one cycle, both use values from before the edge.
- R6: XOR with both operands taken from the same accumulator, written back through the result path, clears that accumulator to zero.
- R7: Reset clears both accumulators and both data registers to zero, empties both FIFOs, and clears all four sticky flags.
- R8: When `d_we` is high outside reset, `d_wdata` is written into D1 if `d_sel` is 1, otherwise into D0. The new value is usable from the next cycle.
- R9: Each FIFO holds up to 4 entries in arrival order. A FIFO is popped once in any run cycle where the active word uses its head as operand B or as a write source.
- R10: A push into a full FIFO is dropped, and that FIFO's overflow flag sets and stays set until reset.
- R11: A pop from an empty FIFO presents the most recently popped value as the head. That FIFO's underflow flag sets and stays set until reset.
- R12: The control store accepts writes only while reset is asserted. Writes while running leave the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables control store loading |
| cfg_addr | input | 3 | Selects the configuration word for the current cycle |
| cs_we | input | 1 | Control store write enable (honoured only during reset) |
| cs_waddr | input | 3 | Control store write address |
| cs_wdata | input | 13 | Control store write data |
| d_we | input | 1 | Data register write enable |
| d_sel | input | 1 | Data register select: 0 for D0, 1 for D1 |
| d_wdata | input | 8 | Data register write value |
| f0_push | input | 1 | Push strobe for FIFO 0 |
| f0_din | input | 8 | Push data for FIFO 0 |
| f1_push | input | 1 | Push strobe for FIFO 1 |
| f1_din | input | 8 | Push data for FIFO 1 |
| result | output | 8 | ALU/shifter output for the active word |
| f0_empty | output | 1 | FIFO 0 empty |
| f0_full | output | 1 | FIFO 0 full |
| f0_ovf | output | 1 | FIFO 0 sticky overflow |
| f0_unf | output | 1 | FIFO 0 sticky underflow |
| f1_empty | output | 1 | FIFO 1 empty |
| f1_full | output | 1 | FIFO 1 full |
| f1_ovf | output | 1 | FIFO 1 sticky overflow |
| f1_unf | output | 1 | FIFO 1 sticky underflow |

## Verification
Some properties are checked by assertions on every cycle:

- the control store stays frozen while running;
- a FIFO never exceeds its depth;
- pushes into a full FIFO are dropped;
- the head holds still on an empty pop;
- the overflow and underflow flags are sticky;
- an accumulator holds whenever its write code is hold;
- the XOR self-clear leaves zero.

Other behaviour only shows up through the bench's programmed sequences:

- the arithmetic of each ALU and shift code;
- the operand routing;
- FIFO ordering;
- the last-value replay on underflow;
- the use of pre-edge values when both accumulators load together.

// File: rtl/ucdp_pkg.sv
package ucdp_pkg;

    typedef enum logic [2:0] {
        ALU_PASS, ALU_INC, ALU_DEC, ALU_ADD,
        ALU_SUB,  ALU_XOR, ALU_AND, ALU_OR
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_PASS, SH_LEFT, SH_RIGHT, SH_SWAP
    } shf_fn_e;

    typedef enum logic {
        SA_A0, SA_A1
    } srca_e;

    typedef enum logic [2:0] {
        SB_D0, SB_D1, SB_F0, SB_F1, SB_A0, SB_A1, SB_RSV6, SB_RSV7
    } srcb_e;

    typedef enum logic [1:0] {
        W0_NONE, W0_SHF, W0_D0, W0_F0
    } wr0_e;

    typedef enum logic [1:0] {
        W1_NONE, W1_SHF, W1_D1, W1_F1
    } wr1_e;

    typedef struct packed {
        alu_fn_e alu;
        shf_fn_e shf;
        srca_e   srca;
        srcb_e   srcb;
        wr0_e    wr0;
        wr1_e    wr1;
    } cfg_word_t;

    localparam int CFG_W = $bits(cfg_word_t);

endpackage

// File: rtl/ucdp_cstore.sv
module ucdp_cstore
    import ucdp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [CFG_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [CFG_W-1:0] rdata
);

    logic [CFG_W-1:0] mem_q [DEPTH];

    // Writes land only in the load phase (reset held).
    always_ff @(posedge clk) begin
        if (rst && we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem_q[raddr];
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_lock
        assert_cstore_frozen_R12: assert property (
            @(posedge clk) disable iff (rst)
            !$past(rst) |-> $stable(mem_q[gi])
        );
    end

endmodule

// File: rtl/ucdp_fifo.sv
module ucdp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic          ovf,
    output logic          unf
);

    logic [DW-1:0]   mem_q [DEPTH];
    logic [PW-1:0]   wp_q, rp_q;
    logic [CNTW-1:0] cnt_q;
    logic [DW-1:0]   last_q;
    logic            push_ok, pop_ok;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == CNTW'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = empty ? last_q : mem_q[rp_q];
    end

    always_ff @(posedge clk) begin
        if (!rst && push_ok) begin
            mem_q[wp_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            last_q <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (push_ok) wp_q <= ptr_inc(wp_q);
            if (pop_ok) begin
                rp_q   <= ptr_inc(rp_q);
                last_q <= mem_q[rp_q];
            end
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push && full)  ovf <= 1'b1;
            if (pop && empty)  unf <= 1'b1;
        end
    end

    assert_fifo_bound_R9: assert property (
        @(posedge clk) disable iff (rst)
        cnt_q <= CNTW'(DEPTH)
    );

    assert_push_full_dropped_R10: assert property (
        @(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && ovf)
    );

    assert_ovf_sticky_R10: assert property (
        @(posedge clk) disable iff (rst)
        ovf |=> ovf
    );

    assert_empty_pop_holds_R11: assert property (
        @(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (empty && unf && $stable(dout))
    );

    assert_unf_sticky_R11: assert property (
        @(posedge clk) disable iff (rst)
        unf |=> unf
    );

endmodule

// File: rtl/ucdp_alu_shift.sv
module ucdp_alu_shift
    import ucdp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  alu_fn_e       alu_fn,
    input  shf_fn_e       shf_fn,
    output logic [DW-1:0] res
);

    logic [DW-1:0] alu_out;

    always_comb begin
        unique case (alu_fn)
            ALU_PASS: alu_out = opa;
            ALU_INC:  alu_out = opa + 1'b1;
            ALU_DEC:  alu_out = opa - 1'b1;
            ALU_ADD:  alu_out = opa + opb;
            ALU_SUB:  alu_out = opa - opb;
            ALU_XOR:  alu_out = opa ^ opb;
            ALU_AND:  alu_out = opa & opb;
            ALU_OR:   alu_out = opa | opb;
        endcase
    end

    always_comb begin
        unique case (shf_fn)
            SH_PASS:  res = alu_out;
            SH_LEFT:  res = {alu_out[DW-2:0], 1'b0};
            SH_RIGHT: res = {1'b0, alu_out[DW-1:1]};
            SH_SWAP:  res = {alu_out[DW/2-1:0], alu_out[DW-1:DW/2]};
        endcase
    end

endmodule

// File: rtl/ucode_dp8.sv
module ucode_dp8
    import ucdp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CS_DEPTH   = 8,
    localparam int CAW       = $clog2(CS_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CAW-1:0]   cfg_addr,
    input  logic             cs_we,
    input  logic [CAW-1:0]   cs_waddr,
    input  logic [CFG_W-1:0] cs_wdata,
    input  logic             d_we,
    input  logic             d_sel,
    input  logic [DW-1:0]    d_wdata,
    input  logic             f0_push,
    input  logic [DW-1:0]    f0_din,
    input  logic             f1_push,
    input  logic [DW-1:0]    f1_din,
    output logic [DW-1:0]    result,
    output logic             f0_empty,
    output logic             f0_full,
    output logic             f0_ovf,
    output logic             f0_unf,
    output logic             f1_empty,
    output logic             f1_full,
    output logic             f1_ovf,
    output logic             f1_unf
);

    logic [CFG_W-1:0] cs_rdata;
    cfg_word_t        cw;
    logic [DW-1:0]    acc0_q, acc1_q, dr0_q, dr1_q;
    logic [DW-1:0]    f0_head, f1_head;
    logic [DW-1:0]    opa, opb, shf_res;
    logic             f0_pop, f1_pop;

    ucdp_cstore #(.DEPTH(CS_DEPTH)) cstore_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cs_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata),
        .raddr (cfg_addr),
        .rdata (cs_rdata)
    );

    always_comb begin
        cw  = cfg_word_t'(cs_rdata);
        opa = (cw.srca == SA_A1) ? acc1_q : acc0_q;
        case (cw.srcb)
            SB_D0:   opb = dr0_q;
            SB_D1:   opb = dr1_q;
            SB_F0:   opb = f0_head;
            SB_F1:   opb = f1_head;
            SB_A0:   opb = acc0_q;
            SB_A1:   opb = acc1_q;
            default: opb = '0;
        endcase
        f0_pop = !rst && ((cw.srcb == SB_F0) || (cw.wr0 == W0_F0));
        f1_pop = !rst && ((cw.srcb == SB_F1) || (cw.wr1 == W1_F1));
    end

    ucdp_alu_shift #(.DW(DW)) alu_i (
        .opa    (opa),
        .opb    (opb),
        .alu_fn (cw.alu),
        .shf_fn (cw.shf),
        .res    (shf_res)
    );

    always_comb begin
        result = shf_res;
    end

    ucdp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) fifo0_i (
        .clk   (clk),
        .rst   (rst),
        .push  (f0_push),
        .din   (f0_din),
        .pop   (f0_pop),
        .dout  (f0_head),
        .empty (f0_empty),
        .full  (f0_full),
        .ovf   (f0_ovf),
        .unf   (f0_unf)
    );

    ucdp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) fifo1_i (
        .clk   (clk),
        .rst   (rst),
        .push  (f1_push),
        .din   (f1_din),
        .pop   (f1_pop),
        .dout  (f1_head),
        .empty (f1_empty),
        .full  (f1_full),
        .ovf   (f1_ovf),
        .unf   (f1_unf)
    );

    // Register state: every source is sampled before the edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc0_q <= '0;
            acc1_q <= '0;
            dr0_q  <= '0;
            dr1_q  <= '0;
        end else begin
            unique case (cw.wr0)
                W0_NONE: acc0_q <= acc0_q;
                W0_SHF:  acc0_q <= shf_res;
                W0_D0:   acc0_q <= dr0_q;
                W0_F0:   acc0_q <= f0_head;
            endcase
            unique case (cw.wr1)
                W1_NONE: acc1_q <= acc1_q;
                W1_SHF:  acc1_q <= shf_res;
                W1_D1:   acc1_q <= dr1_q;
                W1_F1:   acc1_q <= f1_head;
            endcase
            if (d_we) begin
                if (d_sel) dr1_q <= d_wdata;
                else       dr0_q <= d_wdata;
            end
        end
    end

    assert_acc0_hold_R5: assert property (
        @(posedge clk) disable iff (rst)
        (cw.wr0 == W0_NONE) |=> $stable(acc0_q)
    );

    assert_acc1_hold_R5: assert property (
        @(posedge clk) disable iff (rst)
        (cw.wr1 == W1_NONE) |=> $stable(acc1_q)
    );

    assert_xor_clear_R6: assert property (
        @(posedge clk) disable iff (rst)
        ((cw.alu == ALU_XOR) && (cw.wr0 == W0_SHF) &&
         (((cw.srca == SA_A0) && (cw.srcb == SB_A0)) ||
          ((cw.srca == SA_A1) && (cw.srcb == SB_A1))))
        |=> (acc0_q == '0)
    );

    assert_flags_exclusive_R9: assert property (
        @(posedge clk) disable iff (rst)
        $onehot0({f0_empty, f0_full}) && $onehot0({f1_empty, f1_full})
    );

endmodule

// File: tb/ucode_dp8_tb_top.sv
module ucode_dp8_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_addr;
    logic        cs_we;
    logic [2:0]  cs_waddr;
    logic [12:0] cs_wdata;
    logic        d_we, d_sel;
    logic [7:0]  d_wdata;
    logic        f0_push, f1_push;
    logic [7:0]  f0_din, f1_din;
    logic [7:0]  result;
    logic        f0_empty, f0_full, f0_ovf, f0_unf;
    logic        f1_empty, f1_full, f1_ovf, f1_unf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  exp_q [$];
    string       tag_q [$];
    logic [12:0] prog [8];

    always #5 clk = ~clk;

    ucode_dp8 dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr),
        .cs_we(cs_we), .cs_waddr(cs_waddr), .cs_wdata(cs_wdata),
        .d_we(d_we), .d_sel(d_sel), .d_wdata(d_wdata),
        .f0_push(f0_push), .f0_din(f0_din),
        .f1_push(f1_push), .f1_din(f1_din),
        .result(result),
        .f0_empty(f0_empty), .f0_full(f0_full), .f0_ovf(f0_ovf), .f0_unf(f0_unf),
        .f1_empty(f1_empty), .f1_full(f1_full), .f1_ovf(f1_ovf), .f1_unf(f1_unf)
    );

    // Word fields per R1: alu[12:10] shf[9:8] srca[7] srcb[6:4] wr0[3:2] wr1[1:0]
    function automatic logic [12:0] mk(input int alu, input int shf, input int sa,
                                       input int sb, input int w0, input int w1);
        return {3'(alu), 2'(shf), 1'(sa), 3'(sb), 2'(w0), 2'(w1)};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one datapath cycle, expected result goes to the scoreboard.
    task automatic step(input logic [2:0] addr, input logic [7:0] exp, input string req);
        @(negedge clk);
        f0_push = 1'b0; f1_push = 1'b0; d_we = 1'b0; cs_we = 1'b0;
        cfg_addr = addr;
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    // Monitor: compares result shortly before each rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, result, e);
            end
        end
    end

    task automatic load_and_reset();
        @(negedge clk);
        rst = 1'b1; d_we = 1'b0; f0_push = 1'b0; f1_push = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cs_we = 1'b1; cs_waddr = 3'(i); cs_wdata = prog[i];
            @(negedge clk);
        end
        cs_we = 1'b0;
        chk("R7 f0_empty", {7'd0, f0_empty}, 8'd1);
        chk("R7 f1_empty", {7'd0, f1_empty}, 8'd1);
        chk("R7 flags", {4'd0, f0_ovf, f0_unf, f1_ovf, f1_unf}, 8'd0);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_addr = '0; cs_we = 1'b0; cs_waddr = '0; cs_wdata = '0;
        d_we = 1'b0; d_sel = 1'b0; d_wdata = '0;
        f0_push = 1'b0; f1_push = 1'b0; f0_din = '0; f1_din = '0;
        repeat (2) @(negedge clk);

        // Phase A: ALU, shifter, routing, write-back
        prog[0] = mk(0, 0, 0, 0, 0, 0);   // view A0
        prog[1] = mk(0, 0, 1, 0, 0, 0);   // view A1
        prog[2] = mk(3, 0, 0, 0, 1, 0);   // A0 = A0 + D0
        prog[3] = mk(4, 0, 1, 1, 0, 1);   // A1 = A1 - D1
        prog[4] = mk(5, 1, 0, 4, 1, 0);   // A0 = (A0 ^ A0) << 1
        prog[5] = mk(1, 3, 1, 0, 0, 1);   // A1 = swap(A1 + 1)
        prog[6] = mk(6, 2, 0, 5, 1, 0);   // A0 = (A0 & A1) >> 1
        prog[7] = mk(7, 1, 1, 0, 2, 1);   // A0 = D0, A1 = (A1 | D0) << 1
        load_and_reset();

        step(3'd0, 8'h00, "R7 acc0 reset");
        d_we = 1'b1; d_sel = 1'b0; d_wdata = 8'h35;
        step(3'd1, 8'h00, "R7 acc1 reset");
        d_we = 1'b1; d_sel = 1'b1; d_wdata = 8'h0F;
        step(3'd2, 8'h35, "R2 R8 ADD with D0");
        step(3'd0, 8'h35, "R5 A0 written");
        step(3'd3, 8'hF1, "R2 R4 SUB with D1");
        step(3'd1, 8'hF1, "R5 A1 written");
        step(3'd5, 8'h2F, "R3 INC and SWAP");
        step(3'd1, 8'h2F, "R3 A1 after swap");
        step(3'd6, 8'h12, "R3 R4 AND with A1 then right");
        step(3'd0, 8'h12, "R3 A0 after right");
        step(3'd7, 8'h7E, "R1 R3 OR then left");
        step(3'd0, 8'h35, "R5 A0 loaded from D0");
        step(3'd1, 8'h7E, "R5 A1 loaded same edge");
        step(3'd4, 8'h00, "R6 XOR self result");
        step(3'd0, 8'h00, "R6 A0 cleared");
        step(3'd0, 8'h00, "R12 before run write");
        cs_we = 1'b1; cs_waddr = 3'd0; cs_wdata = mk(1, 0, 0, 0, 0, 0);
        step(3'd0, 8'h00, "R12 store unchanged");

        // Phase B: FIFOs, DEC, data register reset
        prog[0] = mk(0, 0, 0, 0, 0, 0);   // view A0
        prog[1] = mk(0, 0, 1, 0, 0, 0);   // view A1
        prog[2] = mk(0, 0, 0, 0, 3, 3);   // A0 <- F0, A1 <- F1
        prog[3] = mk(3, 0, 0, 2, 1, 0);   // A0 = A0 + F0
        prog[4] = mk(2, 0, 1, 1, 0, 1);   // A1 = A1 - 1
        prog[5] = mk(7, 0, 0, 3, 0, 0);   // A0 | F1, no write
        prog[6] = mk(0, 0, 0, 0, 2, 2);   // A0 <- D0, A1 <- D1
        prog[7] = mk(5, 0, 1, 5, 0, 1);   // A1 = A1 ^ A1
        load_and_reset();

        step(3'd4, 8'hFF, "R2 DEC wraps");
        f0_push = 1'b1; f0_din = 8'h11;
        step(3'd1, 8'hFF, "R5 A1 after DEC");
        f0_push = 1'b1; f0_din = 8'h22;
        step(3'd7, 8'h00, "R6 XOR on A1");
        f0_push = 1'b1; f0_din = 8'h33;
        step(3'd1, 8'h00, "R6 A1 cleared");
        f0_push = 1'b1; f0_din = 8'h44;
        step(3'd0, 8'h00, "R9 fill");
        f0_push = 1'b1; f0_din = 8'h55;
        step(3'd3, 8'h11, "R9 first in first out");
        chk("R10 f0_full", {7'd0, f0_full}, 8'd1);
        chk("R10 f0_ovf", {7'd0, f0_ovf}, 8'd1);
        step(3'd3, 8'h33, "R9 second entry");
        step(3'd3, 8'h66, "R9 third entry");
        step(3'd3, 8'hAA, "R9 R10 fourth entry, 55 dropped");
        step(3'd3, 8'hEE, "R11 empty head replays 44");
        step(3'd0, 8'hEE, "R11 A0 after replay");
        chk("R11 f0_empty", {7'd0, f0_empty}, 8'd1);
        chk("R11 f0_unf", {7'd0, f0_unf}, 8'd1);
        chk("R10 f0_ovf sticky", {7'd0, f0_ovf}, 8'd1);
        f1_push = 1'b1; f1_din = 8'h5A;
        step(3'd0, 8'hEE, "R1 view A0");
        f1_push = 1'b1; f1_din = 8'hC3;
        step(3'd2, 8'hEE, "R5 both FIFO loads");
        step(3'd0, 8'h44, "R5 R11 A0 from empty F0");
        step(3'd1, 8'h5A, "R5 A1 from F1");
        step(3'd5, 8'hC7, "R4 OR with F1 head");
        step(3'd5, 8'hC7, "R11 F1 empty replays C3");
        step(3'd6, 8'h44, "R1 view before D load");
        chk("R11 f1_unf", {7'd0, f1_unf}, 8'd1);
        chk("R10 f1_ovf clear", {7'd0, f1_ovf}, 8'd0);
        step(3'd0, 8'h00, "R7 D0 reset to zero");
        step(3'd1, 8'h00, "R7 D1 reset to zero");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule